// File: doc/BRIEF.md
# Counter Enable Set/Clear Register Pair with Security Gating

This block keeps the run/stop state of a group of up to sixteen auxiliary event counters and drives one enable line per counter. Software reaches the state through two 32-bit views at fixed offsets of a small register bus. Both views read back the same state. A write to the clear view turns off the counters whose data bits are 1. A write to the set view turns on the counters whose data bits are 1.

Every access carries the world of its requester. That world, a 3-bit root access field and a non-secure permission bit decide whether the access takes effect or is read-as-zero/write-ignored. Counters that lie beyond the configured implemented count, or that are flagged absent by the per-bit implementation mask, show as zero and cannot be changed. The counters themselves and the registers that drive the gating and configuration inputs live elsewhere and enter only as ports.

Top module: `cnt_enable_regs`

## Requirements
- R1: After reset, every enable bit is 0, `cnt_en` is all zero and `rsp_rdata` is zero.
- R2: A granted write to the clear view (offset 0xC24) clears every live enable bit whose data bit is 1 and leaves bits whose data bit is 0 unchanged.
- R3: A granted write to the set view (offset 0xC04) sets every live enable bit whose data bit is 1 and leaves bits whose data bit is 0 unchanged.
- R4: Both views hold one shared state, so a granted read of either returns the same value: bits [15:0] hold the enable state (1 = running) and bits [31:16] are always zero.
- R5: A bit whose index is at or above `impl_count` reads as zero, drives 0 on `cnt_en` and ignores writes. With `impl_count` = 0 the whole register reads zero.
- R6: A bit whose `impl_mask` bit is 0 reads as zero, drives 0 on `cnt_en` and ignores writes.
- R7: With the root-control option present (`req_world` 00 = secure, 01 = non-secure, 10 = realm, 11 = root), a secure access is refused when `root_ra` is 000 or 001. A realm access is refused when it is 000 or 010. A non-secure access is refused unless it is 011. A root access is always granted. A refused access reads zero and changes nothing.
- R8: With the root-control option absent and access control present, a non-secure access is refused when `ns_allow` is 0. All other accesses are granted.
- R9: Reads of any other offset return zero, and writes to any other offset change no state.
- R10: Read data appears on `rsp_rdata` in the cycle after the request, and is zero otherwise. `cnt_en` shows the result of a write from the cycle after that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset within the block's frame |
| req_wdata | input | 32 | Write data |
| req_world | input | 2 | Requester world: 00 secure, 01 non-secure, 10 realm, 11 root |
| root_ra | input | 3 | Root-level access field |
| ns_allow | input | 1 | Secure-level permission for non-secure access |
| impl_count | input | 5 | Number of implemented counters (0 to 16) |
| impl_mask | input | 16 | Per-counter implemented flag |
| rsp_rdata | output | 32 | Registered read data |
| cnt_en | output | 16 | Per-counter enable |

## Verification
The assertions take for granted that at most one access is presented per cycle, that `impl_count` never exceeds the counter count, and that configuration and gating inputs change only between accesses. The reset check also assumes that reset is held for at least one clock edge. The bench respects all of this. It updates `impl_count`, `impl_mask`, `root_ra` and `ns_allow` only while `req_valid` is low, and it holds reset across several edges. It then sweeps every counter count, several mask patterns and every combination of world, root field and permission bit. A second instance is built without the root-control option.

// File: rtl/cnt_enable_regs.sv
module cnt_enable_regs #(
  parameter int NCTR = 16,
  parameter int DW = 32,
  parameter int AW = 12,
  parameter logic [AW-1:0] CLR_OFS = 12'hC24,
  parameter logic [AW-1:0] SET_OFS = 12'hC04,
  parameter bit HAS_ROOT = 1'b1,
  parameter bit HAS_ACC = 1'b1,
  localparam int CW = $clog2(NCTR + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic            req_write,
  input  logic [AW-1:0]   req_addr,
  input  logic [DW-1:0]   req_wdata,
  input  logic [1:0]      req_world,
  input  logic [2:0]      root_ra,
  input  logic            ns_allow,
  input  logic [CW-1:0]   impl_count,
  input  logic [NCTR-1:0] impl_mask,
  output logic [DW-1:0]   rsp_rdata,
  output logic [NCTR-1:0] cnt_en
);
  logic [DW-1:0] en_q, live, wbits;
  logic hit_clr, hit_set, granted, act;

  for (genvar i = 0; i < DW; i++) begin : g_live
    if (i < NCTR) begin : g_ctr
      assign live[i] = impl_mask[i] && (i < int'(impl_count));
    end else begin : g_rsv
      assign live[i] = 1'b0;
    end
  end

  always_comb begin
    granted = 1'b1;
    if (HAS_ROOT) begin
      case (req_world)
        2'b00:   granted = !(root_ra == 3'b000 || root_ra == 3'b001);
        2'b10:   granted = !(root_ra == 3'b000 || root_ra == 3'b010);
        2'b01:   granted = (root_ra == 3'b011);
        default: granted = 1'b1;
      endcase
    end else if (HAS_ACC) begin
      granted = !(req_world == 2'b01 && !ns_allow);
    end
  end

  assign hit_clr = (req_addr == CLR_OFS);
  assign hit_set = (req_addr == SET_OFS);
  assign act = req_valid && granted && (hit_clr || hit_set);
  assign wbits = req_wdata & live;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= '0;
      rsp_rdata <= '0;
    end else begin
      rsp_rdata <= '0;
      if (act && req_write)
        en_q <= hit_clr ? (en_q & ~wbits) : (en_q | wbits);
      else if (act)
        rsp_rdata <= en_q & live;
    end
  end

  assign cnt_en = en_q[NCTR-1:0] & live[NCTR-1:0];
endmodule

// File: rtl/cnt_enable_chk.sv
module cnt_enable_chk #(
  parameter int NCTR = 16,
  parameter int DW = 32,
  parameter int AW = 12,
  parameter int CW = 5,
  parameter logic [AW-1:0] CLR_OFS = 12'hC24,
  parameter logic [AW-1:0] SET_OFS = 12'hC04
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_write,
  input logic [AW-1:0]   req_addr,
  input logic [CW-1:0]   impl_count,
  input logic [NCTR-1:0] impl_mask,
  input logic [DW-1:0]   rsp_rdata,
  input logic [NCTR-1:0] cnt_en,
  input logic [DW-1:0]   en_q
);
  logic was_rst;
  logic [31:0] lim;
  assign lim = (32'd1 << impl_count) - 32'd1;

  always_ff @(posedge clk) begin
    was_rst <= !rst_n;
    if (was_rst && rst_n)
      assert_reset_clean_R1: assert (en_q == '0 && rsp_rdata == '0)
        else $error("reset state not clean");
  end

  assert_clr_never_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_write && req_addr == CLR_OFS |=> (en_q & ~$past(en_q)) == '0);
  assert_set_never_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_write && req_addr == SET_OFS |=> ($past(en_q) & ~en_q) == '0);
  assert_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_rdata[DW-1:NCTR] == '0);
  assert_count_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en & ~lim[NCTR-1:0]) == '0);
  assert_mask_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en & ~impl_mask) == '0);
  assert_other_still_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_write && (req_addr == CLR_OFS || req_addr == SET_OFS)) |=> $stable(en_q));
  assert_rdata_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid || req_write |=> rsp_rdata == '0);
endmodule

bind cnt_enable_regs cnt_enable_chk #(
  .NCTR(NCTR), .DW(DW), .AW(AW), .CW(CW), .CLR_OFS(CLR_OFS), .SET_OFS(SET_OFS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .impl_count(impl_count), .impl_mask(impl_mask),
  .rsp_rdata(rsp_rdata), .cnt_en(cnt_en), .en_q(en_q)
);

// File: tb/sim_cnt_enable_regs.sv
`timescale 1ns/1ps
module sim_cnt_enable_regs;
  localparam logic [11:0] CLR = 12'hC24, SET = 12'hC04;
  logic clk = 0, rst_n = 0, valid = 0, wr_en = 0, nsa = 1;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rd0, rd1;
  logic [1:0] world = 2'b11;
  logic [2:0] ra = 3'b011;
  logic [4:0] cnt = 5'd16;
  logic [15:0] msk = 16'hFFFF, en0, en1, exp0 = '0, exp1 = '0;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  cnt_enable_regs u0 (.clk(clk), .rst_n(rst_n), .req_valid(valid), .req_write(wr_en),
    .req_addr(addr), .req_wdata(wdata), .req_world(world), .root_ra(ra), .ns_allow(nsa),
    .impl_count(cnt), .impl_mask(msk), .rsp_rdata(rd0), .cnt_en(en0));
  cnt_enable_regs #(.HAS_ROOT(1'b0)) u1 (.clk(clk), .rst_n(rst_n), .req_valid(valid),
    .req_write(wr_en), .req_addr(addr), .req_wdata(wdata), .req_world(world), .root_ra(ra),
    .ns_allow(nsa), .impl_count(cnt), .impl_mask(msk), .rsp_rdata(rd1), .cnt_en(en1));

  function automatic logic [15:0] vm(input logic [4:0] c, input logic [15:0] m);
    logic [31:0] l;
    l = (32'd1 << c) - 32'd1;
    return m & l[15:0];
  endfunction

  function automatic bit ok(input bit root, input logic [1:0] w, input logic [2:0] r, input bit n);
    if (root) begin
      case (w)
        2'b00: return !(r == 3'd0 || r == 3'd1);
        2'b10: return !(r == 3'd0 || r == 3'd2);
        2'b01: return r == 3'd3;
        default: return 1'b1;
      endcase
    end
    return !(w == 2'b01 && !n);
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [1:0] w, input string tag);
    logic [15:0] v;
    @(negedge clk); valid = 1; wr_en = 1; addr = a; wdata = d; world = w;
    @(negedge clk); valid = 0; wr_en = 0;
    v = vm(cnt, msk);
    if (a == CLR || a == SET) begin
      if (ok(1, w, ra, nsa)) exp0 = (a == CLR) ? exp0 & ~(d[15:0] & v) : exp0 | (d[15:0] & v);
      if (ok(0, w, ra, nsa)) exp1 = (a == CLR) ? exp1 & ~(d[15:0] & v) : exp1 | (d[15:0] & v);
    end
    chk({tag, " u0 cnt_en"}, {16'h0, en0}, {16'h0, exp0 & v});
    chk({tag, " u1 cnt_en"}, {16'h0, en1}, {16'h0, exp1 & v});
  endtask

  task automatic rd(input logic [11:0] a, input logic [1:0] w, input string tag);
    logic [15:0] v;
    logic hit;
    @(negedge clk); valid = 1; wr_en = 0; addr = a; world = w;
    @(negedge clk); valid = 0;
    v = vm(cnt, msk);
    hit = (a == CLR || a == SET);
    chk({tag, " u0 rdata"}, rd0, (hit && ok(1, w, ra, nsa)) ? {16'h0, exp0 & v} : 32'h0);
    chk({tag, " u1 rdata"}, rd1, (hit && ok(0, w, ra, nsa)) ? {16'h0, exp1 & v} : 32'h0);
    @(negedge clk);
    chk({tag, " R10 idle rdata"}, rd0 | rd1, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset cnt_en", {en1, en0}, 32'h0);
    chk("R1 reset rdata", rd0 | rd1, 32'h0);
    rd(CLR, 2'b11, "R1 reset read");

    wr(SET, 32'h0000_A5C3, 2'b11, "R3 set pattern");
    rd(CLR, 2'b11, "R4 clear view");
    rd(SET, 2'b11, "R4 set view");
    wr(SET, 32'hFFFF_0000, 2'b11, "R4 upper bits ignored");
    wr(SET, 32'h0000_0000, 2'b11, "R3 zeros unchanged");
    wr(CLR, 32'h0000_0000, 2'b11, "R2 zeros unchanged");
    wr(CLR, 32'h0000_8101, 2'b11, "R2 clear pattern");
    rd(SET, 2'b11, "R4 shared after clear");
    for (int k = 0; k < 16; k++) begin
      wr(SET, 32'h1 << k, 2'b11, "R3 walk set");
      wr(CLR, 32'h1 << ((k + 5) % 16), 2'b11, "R2 walk clear");
    end
    wr(SET, 32'hFFFF_FFFF, 2'b11, "R10 all on");
    rd(CLR, 2'b11, "R10 readback");

    for (int c = 0; c <= 16; c++) begin
      @(negedge clk); cnt = 5'(c);
      rd(CLR, 2'b11, "R5 count view");
      wr(CLR, 32'hFFFF, 2'b11, "R5 clear counted");
      wr(SET, 32'h5A5A, 2'b11, "R5 set counted");
      rd(SET, 2'b11, "R5 count read");
    end
    @(negedge clk); cnt = 5'd0;
    rd(SET, 2'b11, "R5 zero count");

    for (int m = 0; m < 6; m++) begin
      @(negedge clk); cnt = 5'd16;
      msk = (m == 0) ? 16'h0000 : (m == 1) ? 16'hFFFF : (m == 2) ? 16'h00FF :
            (m == 3) ? 16'hAAAA : (m == 4) ? 16'h1248 : 16'h8001;
      rd(CLR, 2'b11, "R6 mask view");
      wr(SET, 32'hFFFF, 2'b11, "R6 set masked");
      wr(CLR, 32'h3C3C, 2'b11, "R6 clear masked");
      rd(SET, 2'b11, "R6 mask read");
    end
    @(negedge clk); msk = 16'hFFFF;

    for (int w = 0; w < 4; w++)
      for (int r = 0; r < 8; r++)
        for (int n = 0; n < 2; n++) begin
          @(negedge clk); ra = 3'(r); nsa = n[0];
          wr(CLR, 32'hFFFF, 2'b11, "R7 root clear");
          wr(SET, 32'h0F0F, 2'(w), "R7 R8 gated set");
          rd(CLR, 2'(w), "R7 R8 gated read");
          wr(CLR, 32'h0F00, 2'(w), "R7 R8 gated clear");
          rd(SET, 2'b11, "R7 R8 root read");
        end

    @(negedge clk); ra = 3'b011; nsa = 1;
    wr(SET, 32'h00F0, 2'b11, "R9 setup");
    wr(12'hC28, 32'hFFFF, 2'b11, "R9 other write");
    wr(12'hC20, 32'hFFFF, 2'b11, "R9 other write low");
    rd(12'hC28, 2'b11, "R9 other read");
    rd(12'h000, 2'b11, "R9 zero offset read");
    rd(CLR, 2'b11, "R9 state kept");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL R10 watchdog got=hung exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule